// File: doc/BRIEF.md
# Clock Pulse Skipper Throttle

This block lowers the effective rate of a clock by turning a free-running clock into a per-cycle enable that drops a programmed share of pulses. A downstream gating cell, which is not part of this block, consumes the enable. The throttle depth is the percentage of pulses to drop. It is given in one of two ways. In percent mode it is a direct 7-bit value. In level mode it is a 2-bit code that selects one of four fixed depths. Typical settings are 85% for a heavy thermal event and 50% for a light one.

The dropped pulses are spread as evenly as possible rather than grouped into bursts. Each cycle, a remainder accumulator adds the pass share (100 minus the depth). A pulse is passed whenever the sum reaches 100, and 100 is then subtracted. A two-state controller sits in front of the accumulator:
- `ST_FULL`: the depth is zero and every pulse passes.
- `ST_THIN`: the accumulator thins the stream.

The controller moves FULL→THIN when the resolved depth becomes nonzero and THIN→FULL when it returns to zero. The resolved depth is registered, so a new setting acts from the cycle after it is sampled. The accumulator is never cleared on a change of setting.

Top module: `pulse_skip_throttle`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `clk_en` is 1 and the accumulator is zero.
- R2: With `use_level`=0, the depth is `depth_pct` (0..99) as a percentage of pulses to skip.
- R3: With `use_level`=1, `level_code`=0 selects a depth of 0%.
- R4: With `use_level`=1, `level_code`=1 selects a depth of 50%.
- R5: With `use_level`=1, `level_code`=2 selects a depth of 75%.
- R6: With `use_level`=1, `level_code`=3 selects a depth of 85%.
- R7: A depth of 0 puts the controller in `ST_FULL`, and `clk_en` is 1 in every cycle.
- R8: A `depth_pct` of 100..127 is clamped to 99, so `clk_en` is never 0 for 100 or more consecutive cycles.
- R9: In each cycle, `clk_en` = 1 exactly when acc + (100 − depth) ≥ 100. The next accumulator value is that sum, minus 100 when a pulse passed. The accumulator stays below 100.
- R10: An input setting sampled at a clock edge governs `clk_en` from that edge on, and the accumulator value carries across the change.
- R11: Over 100 consecutive cycles at a constant depth d, the number of cycles with `clk_en`=1 is 100 − d within ±1.
- R12: `depth_pct` has no effect in level mode, and `level_code` has no effect in percent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose pulses are thinned |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_level | input | 1 | 1: depth from `level_code`; 0: depth from `depth_pct` |
| depth_pct | input | 7 | Direct depth in percent; values above 99 are clamped |
| level_code | input | 2 | Level code: 0=0%, 1=50%, 2=75%, 3=85% |
| clk_en | output | 1 | Per-cycle pulse enable |

## Verification
The bench uses the default parameters: a scale of 100 and a 7-bit percent input. With these settings, all 128 percent codes and all four level codes can be swept exhaustively. Each setting runs for a full window of 100 cycles, checked against a cycle-by-cycle accumulator model and against the pass count of that window. This covers the clamp range 100..127 and the zero-depth bypass. Settings change back to back, so the carried accumulator is exercised at every transition. Each mode is also driven with varying values on the input it should ignore.

// File: rtl/pskip_pkg.sv
package pskip_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MED  = 2'd2,
        LVL_HIGH = 2'd3
    } lvl_e;

    typedef enum logic {
        ST_FULL = 1'b0,
        ST_THIN = 1'b1
    } thr_state_e;

    // Fixed depth table for the level code, in percent.
    function automatic int unsigned level_depth(input logic [1:0] code);
        int unsigned d;
        unique case (lvl_e'(code))
            LVL_NONE: d = 0;
            LVL_LOW:  d = 50;
            LVL_MED:  d = 75;
            LVL_HIGH: d = 85;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pskip_depth_sel.sv
module pskip_depth_sel
    import pskip_pkg::*;
#(
    parameter int unsigned PCT_W     = 7,
    parameter int unsigned SCALE     = 100,
    parameter int unsigned MAX_DEPTH = SCALE - 1,
    localparam int unsigned RATE_W   = $clog2(SCALE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_level,
    input  logic [PCT_W-1:0]  depth_pct,
    input  logic [1:0]        level_code,
    output thr_state_e        state,
    output logic [RATE_W-1:0] pass_rate
);

    localparam logic [PCT_W-1:0] MAX_V = PCT_W'(MAX_DEPTH);

    logic [PCT_W-1:0] raw_depth;
    logic [PCT_W-1:0] lim_depth;
    logic [PCT_W-1:0] depth_q;
    thr_state_e       state_q;
    thr_state_e       state_d;

    // Resolve source, then clamp so the clock never fully stops.
    always_comb begin
        raw_depth = use_level ? PCT_W'(level_depth(level_code)) : depth_pct;
        lim_depth = (raw_depth > MAX_V) ? MAX_V : raw_depth;
    end

    // Next-state decode.
    always_comb begin
        unique case (state_q)
            ST_FULL: state_d = (lim_depth != '0) ? ST_THIN : ST_FULL;
            ST_THIN: state_d = (lim_depth == '0) ? ST_FULL : ST_THIN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= lim_depth;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_FULL: pass_rate = RATE_W'(SCALE);
            ST_THIN: pass_rate = RATE_W'(SCALE - int'(depth_q));
        endcase
    end

    assign state = state_q;

    // R8
    depth_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= MAX_V);

    // R6
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_level && level_code == 2'd3) |=> (pass_rate == RATE_W'(15)));

    // R3
    level_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_level && level_code == 2'd0) |=> (state == ST_FULL));

    // R12
    pct_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_level && $past(use_level) && $stable(level_code)) |=> $stable(pass_rate));

endmodule

// File: rtl/pskip_accum.sv
module pskip_accum
    import pskip_pkg::*;
#(
    parameter int unsigned SCALE   = 100,
    localparam int unsigned RATE_W = $clog2(SCALE + 1),
    localparam int unsigned ACC_W  = $clog2(SCALE),
    localparam int unsigned SUM_W  = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  thr_state_e        state,
    input  logic [RATE_W-1:0] pass_rate,
    output logic              pulse_en
);

    localparam logic [SUM_W-1:0] SCALE_V = SUM_W'(SCALE);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [SUM_W-1:0] sum;
    logic             hit;

    always_comb begin
        sum = SUM_W'(acc_q) + SUM_W'(pass_rate);
        hit = (sum >= SCALE_V);
        unique case (state)
            ST_FULL: begin
                acc_d    = acc_q;
                pulse_en = 1'b1;
            end
            ST_THIN: begin
                acc_d    = hit ? ACC_W'(sum - SCALE_V) : ACC_W'(sum);
                pulse_en = hit;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // Run of consecutive skipped cycles, kept for the stall check.
    logic [RATE_W:0] skip_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        skip_run <= '0;
        else if (pulse_en) skip_run <= '0;
        else               skip_run <= skip_run + 1'b1;
    end

    // R9
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(SCALE));

    // R7
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> pulse_en);

    // R8
    no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_run < (RATE_W+1)'(SCALE));

    // R10
    acc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THIN && !pulse_en) |=> (acc_q != '0));

endmodule

// File: rtl/pulse_skip_throttle.sv
module pulse_skip_throttle
    import pskip_pkg::*;
#(
    parameter int unsigned PCT_W = 7,
    parameter int unsigned SCALE = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_level,
    input  logic [PCT_W-1:0] depth_pct,
    input  logic [1:0]       level_code,
    output logic             clk_en
);

    localparam int unsigned RATE_W = $clog2(SCALE + 1);

    thr_state_e        st;
    logic [RATE_W-1:0] rate;

    pskip_depth_sel #(.PCT_W(PCT_W), .SCALE(SCALE)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_level  (use_level),
        .depth_pct  (depth_pct),
        .level_code (level_code),
        .state      (st),
        .pass_rate  (rate)
    );

    pskip_accum #(.SCALE(SCALE)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (st),
        .pass_rate (rate),
        .pulse_en  (clk_en)
    );

    // R1
    reset_pass_chk: assert property (@(posedge clk)
        (!rst_n) |-> clk_en);

endmodule

// File: tb/tb_pulse_skip_throttle.sv
module tb_pulse_skip_throttle;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_level = 1'b0;
    logic [6:0] depth_pct = '0;
    logic [1:0] level_code = '0;
    logic       clk_en;

    int checks = 0;
    int errors = 0;
    int acc_m = 0;
    int rate_m = 100;
    bit done = 0;

    always #4 clk = ~clk;

    pulse_skip_throttle dut (
        .clk(clk), .rst_n(rst_n), .use_level(use_level),
        .depth_pct(depth_pct), .level_code(level_code), .clk_en(clk_en)
    );

    function automatic int exp_depth(input bit u, input int p, input int l);
        int d;
        if (u) d = (l == 0) ? 0 : (l == 1) ? 50 : (l == 2) ? 75 : 85;
        else   d = (p > 99) ? 99 : p;
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: update model at the edge, compare away from it.
    task automatic step(input string req, inout int cnt);
        int e;
        @(posedge clk);
        if (acc_m + rate_m >= 100) acc_m = acc_m + rate_m - 100;
        else                       acc_m = acc_m + rate_m;
        rate_m = 100 - exp_depth(use_level, int'(depth_pct), int'(level_code));
        @(negedge clk);
        e = (acc_m + rate_m >= 100) ? 1 : 0;
        check(int'(clk_en) == e, req, int'(clk_en), e);
        cnt += int'(clk_en);
    endtask

    task automatic run_cfg(input bit u, input int p, input int l, input string req);
        int cnt = 0;
        int d;
        use_level  = u;
        depth_pct  = 7'(p);
        level_code = 2'(l);
        d = exp_depth(u, p, l);
        for (int i = 0; i < 100; i++) step(req, cnt);
        // R11 window count
        check((cnt >= 99 - d) && (cnt <= 101 - d), "R11", cnt, 100 - d);
    endtask

    initial begin
        string tag;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(clk_en == 1'b1, "R1", int'(clk_en), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_en == 1'b1, "R1", int'(clk_en), 1);
        acc_m = 0; rate_m = 100;

        // Percent mode: every code, level_code toggling (R12)
        for (int p = 0; p < 128; p++) begin
            level_code = 2'(p);
            if (p == 0)       tag = "R7";
            else if (p > 99)  tag = "R8";
            else if (p % 3 == 0) tag = "R12";
            else if (p % 3 == 1) tag = "R2";
            else              tag = "R9";
            run_cfg(1'b0, p, p % 4, tag);
        end

        // Level mode: each code with varying depth_pct (R12)
        run_cfg(1'b1, 37, 0, "R3");
        run_cfg(1'b1, 120, 1, "R4");
        run_cfg(1'b1, 5, 2, "R5");
        run_cfg(1'b1, 99, 3, "R6");
        run_cfg(1'b1, 0, 3, "R12");
        run_cfg(1'b1, 64, 2, "R12");

        // R10: rapid changes every few cycles, accumulator carried
        for (int k = 0; k < 60; k++) begin
            int c = 0;
            use_level = k[0];
            depth_pct = 7'((k * 37) % 128);
            level_code = 2'(k / 2);
            for (int j = 0; j < 3 + (k % 5); j++) step("R10", c);
        end

        // Back to full, then to 99: clock never stalls (R8)
        run_cfg(1'b0, 0, 0, "R7");
        run_cfg(1'b0, 127, 0, "R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule